// File: doc/BRIEF.md
# 8x4 Inverse Transform With Reconstruction

This block rebuilds one 8-pixel-wide, 4-row-tall area of a picture from dequantised transform coefficients and a matching area of prediction pixels. The caller pulses `start`, then streams the four coefficient rows, one row per beat. Each row passes through an 8-point integer inverse kernel as it arrives, and the result is kept in a small row store.

Once all four rows are held, the caller streams the four prediction rows in order, one 8-pixel row per beat. For each prediction row the block runs the 4-point column kernel on all eight columns and picks out the residual line for that row. It adds each residual to its pixel, clamps the sum to the 8-bit range and registers the reconstructed row. `done` marks the last row. Addressing in the frame buffer is left to the surrounding system.

Top module: `inv_xform_8x4_recon`

## Requirements
- R1: While reset is held and in the cycle after it, `rec_vld` and `done` are low.
- R2: Coefficient beat k, counted from the cycle after `start`, is row k. Its column j sits in bits [16j+15:16j]. Each row is transformed with the 8-point kernel: even part weights 12/16/6, odd part weights 16/15/9/4, plus 4, then an arithmetic shift right by 3. Each result is truncated to 16 bits.
- R3: Each column of four row results goes through the 4-point kernel: x0 weighted 17 with 64 added, x2 weighted 17, x1 and x3 weighted 22 and 10. The outputs are y0=a+c, y1=b-d, y2=b+d, y3=a-c. An arithmetic shift right by 7 follows with no further bias, then truncation to 16 bits.
- R4: Prediction pixel j sits in bits [8j+7:8j] of `pred_row`, and the same position is used in `rec_row`. The reconstructed pixel is residual plus zero-extended pixel, clamped to 0..255.
- R5: A prediction beat that is accepted produces `rec_vld` with the reconstructed row one cycle later. Rows come out in order 0..3, and back-to-back beats are allowed.
- R6: `done` is high for exactly one cycle, together with the fourth reconstructed row, and the block then waits for a new `start`.
- R7: Coefficient beats after the fourth one of a block are ignored. This includes beats that arrive while prediction rows are being reconstructed.
- R8: A prediction beat is ignored (no `rec_vld`) while the block is idle or before all four coefficient rows of the block have been taken.
- R9: A `start` pulse while a block is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a block when idle |
| coef_vld | input | 1 | Coefficient row beat valid |
| coef_row | input | 128 | Eight signed 16-bit coefficients of one row |
| pred_vld | input | 1 | Prediction row beat valid |
| pred_row | input | 64 | Eight unsigned 8-bit prediction pixels |
| rec_vld | output | 1 | Reconstructed row valid |
| rec_row | output | 64 | Eight reconstructed 8-bit pixels |
| done | output | 1 | High with the last reconstructed row of a block |

## Verification
Reconstruction of a prediction row and the arrival of a surplus coefficient beat can fall in the same cycle. The bench provokes this by driving stray coefficient rows on every cycle in which it streams prediction rows. It judges the result by comparing each reconstructed row with a model computed from the first four coefficient rows only. A second overlap is a `start` or an early prediction beat arriving while coefficients are still being loaded. These are judged the same way, and the bench also checks that no `rec_vld` appears for the early beat.

// File: rtl/xf84_pkg.sv
// Shared arithmetic type and kernel constants for the 8x4 inverse transform.
// Assumes coefficients of at most 16 bits, so 32-bit accumulators never overflow.
package xf84_pkg;
    typedef logic signed [31:0] acc_t;

    parameter acc_t ROW_RND = 32'sd4;
    parameter int   ROW_SH  = 3;
    parameter acc_t COL_RND = 32'sd64;
    parameter int   COL_SH  = 7;
endpackage

// File: rtl/xf84_row8.sv
// 8-point row kernel, combinational.
// Takes eight signed coefficients and returns eight row results, each shifted
// right by ROW_SH and truncated to COEF_W bits. Assumes COEF_W <= 16.
module xf84_row8 #(
    parameter int COEF_W = 16
) (
    input  logic [8*COEF_W-1:0] coef_in,
    output logic [8*COEF_W-1:0] res_out
);
    import xf84_pkg::*;

    acc_t s  [8];
    acc_t ev [4];
    acc_t od [4];
    acc_t y  [8];
    acc_t e0, e1, e2, e3;

    // Butterfly evaluation of even and odd halves, then recombination.
    always_comb begin
        for (int i = 0; i < 8; i++) begin
            s[i] = acc_t'($signed(coef_in[i*COEF_W +: COEF_W]));
        end
        e0 = 12 * (s[0] + s[4]) + ROW_RND;
        e1 = 12 * (s[0] - s[4]) + ROW_RND;
        e2 = 16 * s[2] + 6 * s[6];
        e3 = 6 * s[2] - 16 * s[6];
        ev[0] = e0 + e2;
        ev[1] = e1 + e3;
        ev[2] = e1 - e3;
        ev[3] = e0 - e2;
        od[0] = 16 * s[1] + 15 * s[3] + 9 * s[5] + 4 * s[7];
        od[1] = 15 * s[1] - 4 * s[3] - 16 * s[5] - 9 * s[7];
        od[2] = 9 * s[1] - 16 * s[3] + 4 * s[5] + 15 * s[7];
        od[3] = 4 * s[1] - 9 * s[3] + 15 * s[5] - 16 * s[7];
        for (int k = 0; k < 4; k++) begin
            y[k]     = ev[k] + od[k];
            y[7 - k] = ev[k] - od[k];
        end
        for (int i = 0; i < 8; i++) begin
            res_out[i*COEF_W +: COEF_W] = COEF_W'(y[i] >>> ROW_SH);
        end
    end
endmodule

// File: rtl/xf84_col4.sv
// 4-point column kernel, combinational.
// Takes four row results of one column (row 0 in the low slice) and returns the
// four residuals, each shifted right by COL_SH with no extra bias and
// truncated to COEF_W bits.
module xf84_col4 #(
    parameter int COEF_W = 16
) (
    input  logic [4*COEF_W-1:0] col_in,
    output logic [4*COEF_W-1:0] col_out
);
    import xf84_pkg::*;

    acc_t x [4];
    acc_t y [4];
    acc_t p, q, a, b, c, d;

    // Even/odd split of the four inputs, then the output butterfly.
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            x[k] = acc_t'($signed(col_in[k*COEF_W +: COEF_W]));
        end
        p = 17 * x[0] + COL_RND;
        q = 17 * x[2];
        a = p + q;
        b = p - q;
        c = 22 * x[1] + 10 * x[3];
        d = 22 * x[3] - 10 * x[1];
        y[0] = a + c;
        y[1] = b - d;
        y[2] = b + d;
        y[3] = a - c;
        for (int k = 0; k < 4; k++) begin
            col_out[k*COEF_W +: COEF_W] = COEF_W'(y[k] >>> COL_SH);
        end
    end
endmodule

// File: rtl/xf84_recon.sv
// Adds one signed residual to one unsigned prediction pixel and clamps the sum
// to 0..2^PIX_W-1. Assumes COEF_W >= PIX_W.
module xf84_recon #(
    parameter int COEF_W = 16,
    parameter int PIX_W  = 8
) (
    input  logic [COEF_W-1:0] resid,
    input  logic [PIX_W-1:0]  pred_px,
    output logic [PIX_W-1:0]  rec_px
);
    localparam int SUM_W = COEF_W + 2;
    localparam logic signed [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

    logic signed [SUM_W-1:0] sum;

    // Widened add followed by a two-sided clamp.
    always_comb begin
        sum = SUM_W'($signed(resid)) + $signed({{(SUM_W-PIX_W){1'b0}}, pred_px});
        if (sum < 0)
            rec_px = '0;
        else if (sum > PIX_MAX)
            rec_px = '1;
        else
            rec_px = sum[PIX_W-1:0];
    end
endmodule

// File: rtl/inv_xform_8x4_recon.sv
// 8x4 inverse transform with reconstruction.
// After start, takes four coefficient rows and runs the row kernel on each as
// it arrives. Then, for every prediction row, runs the column kernels and emits
// the clamped reconstructed row one cycle later. Assumes beats come no earlier
// than the cycle after start; surplus or early beats are dropped.
module inv_xform_8x4_recon #(
    parameter int COEF_W = 16,
    parameter int PIX_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 coef_vld,
    input  logic [8*COEF_W-1:0]  coef_row,
    input  logic                 pred_vld,
    input  logic [8*PIX_W-1:0]   pred_row,
    output logic                 rec_vld,
    output logic [8*PIX_W-1:0]   rec_row,
    output logic                 done
);
    localparam int ROWS    = 4;
    localparam int COLS    = 8;
    localparam int IDX_W   = $clog2(ROWS);
    localparam int CNT_W   = $clog2(ROWS + 1);
    localparam int LINE_CW = COLS * COEF_W;
    localparam int LINE_PW = COLS * PIX_W;

    logic               active;
    logic [CNT_W-1:0]   rows_got;
    logic [IDX_W-1:0]   pred_idx;
    logic [LINE_CW-1:0] rowbuf [ROWS];
    logic [LINE_CW-1:0] row_res;
    logic [LINE_PW-1:0] rec_next;
    logic               rows_full;
    logic               coef_take;
    logic               pred_take;
    logic               last_pred;

    assign rows_full = (rows_got == CNT_W'(ROWS));
    assign coef_take = active && coef_vld && !rows_full;
    assign pred_take = active && pred_vld && rows_full;
    assign last_pred = (pred_idx == IDX_W'(ROWS - 1));

    xf84_row8 #(.COEF_W(COEF_W)) u_row (
        .coef_in (coef_row),
        .res_out (row_res)
    );

    genvar j;
    generate
        for (j = 0; j < COLS; j++) begin : g_col
            logic [ROWS*COEF_W-1:0] gath;
            logic [ROWS*COEF_W-1:0] cout;
            logic [COEF_W-1:0]      resid;

            // Collect column j from the four stored row results.
            always_comb begin
                for (int k = 0; k < ROWS; k++) begin
                    gath[k*COEF_W +: COEF_W] = rowbuf[k][j*COEF_W +: COEF_W];
                end
            end

            xf84_col4 #(.COEF_W(COEF_W)) u_col (
                .col_in  (gath),
                .col_out (cout)
            );

            assign resid = cout[pred_idx*COEF_W +: COEF_W];

            xf84_recon #(.COEF_W(COEF_W), .PIX_W(PIX_W)) u_rec (
                .resid   (resid),
                .pred_px (pred_row[j*PIX_W +: PIX_W]),
                .rec_px  (rec_next[j*PIX_W +: PIX_W])
            );
        end
    endgenerate

    // Block sequencing: start, coefficient row count, prediction row count, flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            rows_got <= '0;
            pred_idx <= '0;
            rec_vld  <= 1'b0;
            done     <= 1'b0;
        end else begin
            rec_vld <= pred_take;
            done    <= pred_take && last_pred;
            if (!active && start) begin
                active   <= 1'b1;
                rows_got <= '0;
                pred_idx <= '0;
            end
            if (coef_take)
                rows_got <= rows_got + 1'b1;
            if (pred_take) begin
                pred_idx <= pred_idx + 1'b1;
                if (last_pred)
                    active <= 1'b0;
            end
        end
    end

    // Data path registers: row store and reconstructed output row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_row <= '0;
        end else begin
            if (coef_take)
                rowbuf[rows_got[IDX_W-1:0]] <= row_res;
            if (pred_take)
                rec_row <= rec_next;
        end
    end
endmodule

// File: rtl/xf84_chk.sv
// Protocol checker for inv_xform_8x4_recon, attached by bind.
// Observes ports plus the block's sequencing state.
module xf84_chk #(
    parameter int CNT_W = 3,
    parameter int ROWS  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             pred_vld,
    input logic             rec_vld,
    input logic             done,
    input logic             active,
    input logic [CNT_W-1:0] rows_got
);
    // R1: outputs quiet during and right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!rec_vld && !done));

    // R5: an output row only follows an accepted prediction beat
    p_vld_after_pred_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rec_vld |-> ($past(pred_vld) && $past(active) && $past(rows_got) == CNT_W'(ROWS)));

    // R6: done comes with a row, lasts one cycle and ends the block
    p_done_with_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rec_vld && !active));
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: coefficient count never passes the block height
    p_rows_capped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rows_got <= CNT_W'(ROWS));

    // R8: no output for a beat taken while idle or before the rows are full
    p_early_pred_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active || rows_got != CNT_W'(ROWS)) |=> !rec_vld);

    // R9: start during a block does not clear the row count
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && start) |=> ($past(rows_got) == '0 || rows_got != '0));
endmodule

bind inv_xform_8x4_recon xf84_chk #(.CNT_W(CNT_W), .ROWS(ROWS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .pred_vld (pred_vld),
    .rec_vld  (rec_vld),
    .done     (done),
    .active   (active),
    .rows_got (rows_got)
);

// File: tb/inv_xform_8x4_recon_tb.sv
`timescale 1ns/1ps
// Self-checking bench: directed clamp, zero and full-range blocks plus seeded
// random blocks with overlapping stray beats, compared against a matrix model.
module inv_xform_8x4_recon_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         coef_vld = 1'b0;
    logic [127:0] coef_row = '0;
    logic         pred_vld = 1'b0;
    logic [63:0]  pred_row = '0;
    logic         rec_vld;
    logic [63:0]  rec_row;
    logic         done;

    int n_chk = 0;
    int n_fail = 0;
    int c  [4][8];
    int p  [4][8];
    int ex [4][8];

    int RT [8][8] = '{
        '{12, 12, 12, 12, 12, 12, 12, 12},
        '{16, 15, 9, 4, -4, -9, -15, -16},
        '{16, 6, -6, -16, -16, -6, 6, 16},
        '{15, -4, -16, -9, 9, 16, 4, -15},
        '{12, -12, -12, 12, 12, -12, -12, 12},
        '{9, -16, 4, 15, -15, -4, 16, -9},
        '{6, -16, 16, -6, -6, 16, -16, 6},
        '{4, -9, 15, -16, 16, -15, 9, -4}};
    int CT [4][4] = '{
        '{17, 17, 17, 17},
        '{22, 10, -10, -22},
        '{17, -17, -17, 17},
        '{10, -22, 22, -10}};

    always #2 clk = ~clk;

    inv_xform_8x4_recon u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .coef_vld(coef_vld), .coef_row(coef_row),
        .pred_vld(pred_vld), .pred_row(pred_row),
        .rec_vld(rec_vld), .rec_row(rec_row), .done(done));

    function automatic int t16(int v);
        shortint s;
        s = shortint'(v);
        return int'(s);
    endfunction

    // Model of R2, R3 and R4 from the kernel matrices.
    task automatic build_expect();
        int rb [4][8];
        for (int r = 0; r < 4; r++)
            for (int k = 0; k < 8; k++) begin
                int acc = 4;
                for (int i = 0; i < 8; i++) acc += RT[i][k] * c[r][i];
                rb[r][k] = t16(acc >>> 3);
            end
        for (int j = 0; j < 8; j++)
            for (int k = 0; k < 4; k++) begin
                int acc = 64;
                int sum;
                for (int i = 0; i < 4; i++) acc += CT[i][k] * rb[i][j];
                sum = t16(acc >>> 7) + p[k][j];
                ex[k][j] = (sum < 0) ? 0 : (sum > 255) ? 255 : sum;
            end
    endtask

    function automatic logic [127:0] pack_c(int r);
        logic [127:0] v;
        for (int j = 0; j < 8; j++) v[16*j +: 16] = 16'(c[r][j]);
        return v;
    endfunction

    function automatic logic [63:0] pack_p(int r);
        logic [63:0] v;
        for (int j = 0; j < 8; j++) v[8*j +: 8] = 8'(p[r][j]);
        return v;
    endfunction

    function automatic logic [63:0] pack_e(int r);
        logic [63:0] v;
        for (int j = 0; j < 8; j++) v[8*j +: 8] = 8'(ex[r][j]);
        return v;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] rand_row();
        logic [127:0] v;
        for (int j = 0; j < 4; j++) v[32*j +: 32] = $urandom;
        return v;
    endfunction

    task automatic fill_coef(int span);
        for (int r = 0; r < 4; r++)
            for (int j = 0; j < 8; j++)
                c[r][j] = (span == 0) ? 0 : int'($urandom % (2 * span + 1)) - span;
    endtask

    task automatic fill_pix(int lo, int hi);
        for (int r = 0; r < 4; r++)
            for (int j = 0; j < 8; j++)
                p[r][j] = lo + int'($urandom % (hi - lo + 1));
    endtask

    // One block; junk overlaps stray coefficient beats with reconstruction (R7),
    // restart pulses start mid-load (R9), early sends a premature pred beat (R8).
    task automatic run_block(bit junk, bit restart, bit early);
        build_expect();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int r = 0; r < 4; r++) begin
            coef_vld = 1'b1;
            coef_row = pack_c(r);
            if (early && r == 1) begin
                pred_vld = 1'b1;
                pred_row = pack_p(0);
            end
            @(negedge clk);
            coef_vld = 1'b0;
            pred_vld = 1'b0;
            if (early && r == 1)
                check(rec_vld == 1'b0, "R8 early prediction beat", 64'(rec_vld), 64'd0);
            if (restart && r == 1) begin
                start = 1'b1;
                @(negedge clk) start = 1'b0;
            end
        end
        for (int r = 0; r < 4; r++) begin
            pred_vld = 1'b1;
            pred_row = pack_p(r);
            if (junk) begin
                coef_vld = 1'b1;
                coef_row = rand_row();
            end
            @(negedge clk);
            check(rec_vld == 1'b1, "R5 row valid", 64'(rec_vld), 64'd1);
            check(rec_row == pack_e(r), "R2 R3 R4 R7 R9 row data", rec_row, pack_e(r));
            check(done == (r == 3), "R6 done timing", 64'(done), 64'(r == 3));
        end
        pred_vld = 1'b0;
        coef_vld = 1'b0;
        @(negedge clk);
        check(!rec_vld && !done, "R6 quiet after block", {62'd0, rec_vld, done}, 64'd0);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        check(!rec_vld && !done, "R1 reset state", {62'd0, rec_vld, done}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rec_vld && !done, "R1 after reset", {62'd0, rec_vld, done}, 64'd0);

        // R3: all-zero coefficients leave pixels unchanged (no extra bias)
        fill_coef(0); fill_pix(0, 255);
        run_block(1'b0, 1'b0, 1'b0);
        // R4: large positive DC clamps to 255
        fill_coef(0); c[0][0] = 2000; fill_pix(0, 255);
        run_block(1'b0, 1'b0, 1'b0);
        // R4: large negative DC clamps to 0
        fill_coef(0); c[0][0] = -2000; fill_pix(0, 255);
        run_block(1'b0, 1'b0, 1'b0);
        // R4: horizontal ramp crossing both bounds near the pixel edges
        fill_coef(0); c[0][1] = 1500; c[1][0] = 400; fill_pix(0, 20);
        run_block(1'b0, 1'b0, 1'b0);
        fill_pix(235, 255);
        run_block(1'b0, 1'b0, 1'b0);
        // R2 R3: full 16-bit coefficients exercise truncation between passes
        fill_coef(32767); fill_pix(0, 255);
        run_block(1'b1, 1'b0, 1'b0);
        // R7 R8 R9: all overlaps together on one directed block
        fill_coef(300); fill_pix(0, 255);
        run_block(1'b1, 1'b1, 1'b1);

        // Seeded random blocks with random overlap choices
        for (int b = 0; b < 40; b++) begin
            fill_coef((b % 4 == 0) ? 2000 : 300);
            fill_pix(0, 255);
            run_block(1'($urandom), 1'($urandom), 1'($urandom));
        end

        // R8: prediction beat while idle produces nothing
        pred_vld = 1'b1;
        pred_row = 64'h0123_4567_89ab_cdef;
        @(negedge clk);
        pred_vld = 1'b0;
        check(rec_vld == 1'b0, "R8 idle prediction beat", 64'(rec_vld), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule